// File: doc/BRIEF.md
# Framebuffer Pixel Format Unpacker

This block sits between a framebuffer word fetcher and the palette or colour stage of a display pipeline. It takes 32-bit framebuffer words on a valid/ready input stream and emits one pixel per output transfer. A three-bit depth code selects the pixel layout. Depths of 8 bits or fewer produce palette indices. The 16, 32 and 12-bit depths produce 8-bit-per-channel RGB. Further controls can reverse the byte order of each word, reverse the order of sub-byte pixels inside each byte, and swap red and blue. A two-bit external select chooses how the generic 16-bit depth is read.

The configuration is captured together with each word, so software can reprogram the controls while a word is still being unpacked. Every pixel of a word leaves the block before the next word is taken. A separate combinational output gives the number of framebuffer bytes that one display line occupies, from the programmed depth and a column count.

Top module: `fb_unpack`

## Requirements
- R1: While reset is high and on the first cycle after it, out_valid is 0 and in_ready is 1.
- R2: A word is taken on a clock edge where in_valid and in_ready are both 1. in_ready stays 0 while any pixel of the held word is still pending, so input offered then is ignored. A pixel shown with out_valid=1 and out_ready=0 stays unchanged on the next cycle.
- R3: Depth codes 0..7 mean 1, 2, 4, 8, 16, 32, 16 (565) and 12 bits per pixel. A word yields 32, 16, 8, 4, 2, 1, 2 and 2 pixels in that order of codes, with 12-bit pixels held in 16-bit slots. After the last pixel, out_valid falls and in_ready rises.
- R4: With both order controls clear, pixel k is taken from bit offset k*slot_width, counting up from bit 0 of the word.
- R5: With pixel order set and byte order clear, sub-byte pixels inside each byte are taken from the most significant end first, and the bytes are still taken from byte 0 up. At 8 bits per pixel and above this control has no effect.
- R6: With byte order set, the four bytes of the word are reversed (bits 31:24 become byte 0) before unpacking as in R4. The pixel order control is then ignored.
- R7: At depth codes 0..3, out_is_index=1 and out_index holds the pixel zero-extended to 8 bits, with out_r, out_g and out_b all 0. For every other code out_is_index=0 and out_index=0.
- R8: At code 5, red=bits 7:0, green=15:8, blue=23:16, and bits 31:24 are ignored. At code 7, red=bits 3:0, green=7:4, blue=11:8, each shifted left by 4, and bits 15:12 are ignored. Code 6 is always 565.
- R9: In 565, red=bits 4:0 shifted left by 3, green=bits 10:5 shifted left by 2, blue=bits 15:11 shifted left by 3. In 5551, red=bits 4:0, green=9:5, blue=14:10, each shifted left by 3, and bit 15 is ignored.
- R10: With NATIVE_565=0 and depth code 4, the mux select works as follows: 1 means 5551; 0 and 2 mean 565 with the swap control obeyed; 3 means 565 with red and blue always swapped. With NATIVE_565=1, code 4 is 5551 and the mux select is ignored.
- R11: With the swap control set, direct-colour outputs exchange the red and blue values. Palette indices are unaffected.
- R12: bytes_per_line equals cols>>3, cols>>2, cols>>1, cols, cols<<1 and cols<<2 for 1, 2, 4, 8, 16/12 and 32 bits per pixel, across all eight codes.
- R13: The controls are sampled when a word is accepted. Changing them while that word is being unpacked does not alter its pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_depth | input | 3 | Depth code |
| cfg_swap_rb | input | 1 | Swap red and blue |
| cfg_be_byte | input | 1 | Reverse bytes within a word |
| cfg_be_pix | input | 1 | Sub-byte pixels most significant first |
| mux_sel | input | 2 | External 16-bit layout select |
| cfg_cols | input | COL_W | Columns per line |
| bytes_per_line | output | COL_W+2 | Bytes one line occupies |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word ready |
| in_word | input | 32 | Framebuffer word |
| out_valid | output | 1 | Pixel valid |
| out_ready | input | 1 | Pixel ready |
| out_is_index | output | 1 | 1 for palette index, 0 for RGB |
| out_index | output | 8 | Palette index |
| out_r | output | 8 | Red |
| out_g | output | 8 | Green |
| out_b | output | 8 | Blue |

## Verification
Directed words with a single set bit, or a distinct value in each byte, separate the three ordering modes. A wrong byte or pixel position then moves the lone bit to a different pixel number. Random words cover every depth code, mux value and control combination. Here the channel field boundaries of 5551, 565, 444 and 888 show up as wrong channel values, and the ignored top bits are exercised as well. The controls are scrambled and junk input is offered while each word drains, so configuration capture and input blocking are tested. Random output stalls show whether a pixel holds steady.

// File: rtl/fbu_pkg.sv
package fbu_pkg;

    localparam int WORD_W  = 32;
    localparam int CHAN_W  = 8;
    localparam int POS_W   = 5;

    typedef enum logic [2:0] {
        DEPTH_1   = 3'd0,
        DEPTH_2   = 3'd1,
        DEPTH_4   = 3'd2,
        DEPTH_8   = 3'd3,
        DEPTH_16  = 3'd4,
        DEPTH_32  = 3'd5,
        DEPTH_565 = 3'd6,
        DEPTH_12  = 3'd7
    } depth_e;

    typedef enum logic [2:0] {
        FMT_INDEX,
        FMT_5551,
        FMT_565,
        FMT_444,
        FMT_888
    } fmt_e;

    typedef struct packed {
        depth_e     depth;
        logic       swap_rb;
        logic       be_byte;
        logic       be_pix;
        logic [1:0] mux;
    } cfg_t;

    typedef struct packed {
        logic              is_index;
        logic [CHAN_W-1:0] index;
        logic [CHAN_W-1:0] r;
        logic [CHAN_W-1:0] g;
        logic [CHAN_W-1:0] b;
    } pix_t;

    function automatic logic [5:0] slot_width(depth_e d);
        case (d)
            DEPTH_1:  return 6'd1;
            DEPTH_2:  return 6'd2;
            DEPTH_4:  return 6'd4;
            DEPTH_8:  return 6'd8;
            DEPTH_32: return 6'd32;
            default:  return 6'd16;
        endcase
    endfunction

    function automatic logic [5:0] pix_per_word(depth_e d);
        case (d)
            DEPTH_1:  return 6'd32;
            DEPTH_2:  return 6'd16;
            DEPTH_4:  return 6'd8;
            DEPTH_8:  return 6'd4;
            DEPTH_32: return 6'd1;
            default:  return 6'd2;
        endcase
    endfunction

    function automatic logic [CHAN_W-1:0] widen5(logic [4:0] v);
        return {v, 3'b000};
    endfunction

    function automatic logic [CHAN_W-1:0] widen6(logic [5:0] v);
        return {v, 2'b00};
    endfunction

    function automatic logic [CHAN_W-1:0] widen4(logic [3:0] v);
        return {v, 4'b0000};
    endfunction

endpackage

// File: rtl/fbu_line_bytes.sv
module fbu_line_bytes
    import fbu_pkg::*;
#(
    parameter int COL_W = 12
) (
    input  depth_e           depth,
    input  logic [COL_W-1:0] cols,
    output logic [COL_W+1:0] bytes
);
    localparam int OUT_W = COL_W + 2;

    logic [OUT_W-1:0] cols_x;
    assign cols_x = OUT_W'(cols);

    always_comb begin
        case (depth)
            DEPTH_1:  bytes = cols_x >> 3;
            DEPTH_2:  bytes = cols_x >> 2;
            DEPTH_4:  bytes = cols_x >> 1;
            DEPTH_8:  bytes = cols_x;
            DEPTH_32: bytes = cols_x << 2;
            default:  bytes = cols_x << 1;
        endcase
    end
endmodule

// File: rtl/fbu_byte_order.sv
module fbu_byte_order
    import fbu_pkg::*;
(
    input  logic [WORD_W-1:0] word_in,
    input  logic              reverse,
    output logic [WORD_W-1:0] word_out
);
    localparam int NBYTES = WORD_W / 8;

    logic [WORD_W-1:0] flipped;

    genvar gi;
    generate
        for (gi = 0; gi < NBYTES; gi++) begin : g_lane
            assign flipped[gi*8 +: 8] = word_in[(NBYTES-1-gi)*8 +: 8];
        end
    endgenerate

    assign word_out = reverse ? flipped : word_in;
endmodule

// File: rtl/fbu_pix_select.sv
module fbu_pix_select
    import fbu_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  depth_e            depth,
    input  logic              be_pix,
    input  logic              be_byte,
    input  logic [POS_W-1:0]  pos,
    output logic [WORD_W-1:0] raw
);
    logic [5:0]        width;
    logic [9:0]        lin_off;
    logic [9:0]        off;
    logic [32:0]       one_sh;
    logic [WORD_W-1:0] mask;
    logic              sub_byte;

    assign width    = slot_width(depth);
    assign lin_off  = 10'(pos) * 10'(width);
    assign sub_byte = (width < 6'd8);

    always_comb begin
        if (sub_byte && be_pix && !be_byte)
            off = {lin_off[9:3], 3'b000} + (10'd8 - 10'(width) - {7'd0, lin_off[2:0]});
        else
            off = lin_off;
    end

    assign one_sh = 33'd1 << width;
    assign mask   = one_sh[WORD_W-1:0] - 32'd1;
    assign raw    = (word >> off[4:0]) & mask;
endmodule

// File: rtl/fbu_color_decode.sv
module fbu_color_decode
    import fbu_pkg::*;
#(
    parameter bit NATIVE_565 = 1'b0
) (
    input  logic [WORD_W-1:0] raw,
    input  cfg_t              cfg,
    output pix_t              pix
);
    fmt_e              fmt;
    logic              swap;
    logic [CHAN_W-1:0] ch_lo;
    logic [CHAN_W-1:0] ch_mid;
    logic [CHAN_W-1:0] ch_hi;

    always_comb begin
        swap = cfg.swap_rb;
        case (cfg.depth)
            DEPTH_1, DEPTH_2, DEPTH_4, DEPTH_8: fmt = FMT_INDEX;
            DEPTH_32:  fmt = FMT_888;
            DEPTH_565: fmt = FMT_565;
            DEPTH_12:  fmt = FMT_444;
            default: begin
                if (NATIVE_565) begin
                    fmt = FMT_5551;
                end else begin
                    case (cfg.mux)
                        2'd1:    fmt = FMT_5551;
                        2'd3: begin
                            fmt  = FMT_565;
                            swap = 1'b1;
                        end
                        default: fmt = FMT_565;
                    endcase
                end
            end
        endcase
    end

    always_comb begin
        case (fmt)
            FMT_5551: begin
                ch_lo  = widen5(raw[4:0]);
                ch_mid = widen5(raw[9:5]);
                ch_hi  = widen5(raw[14:10]);
            end
            FMT_565: begin
                ch_lo  = widen5(raw[4:0]);
                ch_mid = widen6(raw[10:5]);
                ch_hi  = widen5(raw[15:11]);
            end
            FMT_444: begin
                ch_lo  = widen4(raw[3:0]);
                ch_mid = widen4(raw[7:4]);
                ch_hi  = widen4(raw[11:8]);
            end
            FMT_888: begin
                ch_lo  = raw[7:0];
                ch_mid = raw[15:8];
                ch_hi  = raw[23:16];
            end
            default: begin
                ch_lo  = '0;
                ch_mid = '0;
                ch_hi  = '0;
            end
        endcase
    end

    always_comb begin
        pix          = '0;
        pix.is_index = (fmt == FMT_INDEX);
        if (fmt == FMT_INDEX) begin
            pix.index = raw[CHAN_W-1:0];
        end else begin
            pix.g = ch_mid;
            pix.r = swap ? ch_hi : ch_lo;
            pix.b = swap ? ch_lo : ch_hi;
        end
    end
endmodule

// File: rtl/fb_unpack.sv
module fb_unpack
    import fbu_pkg::*;
#(
    parameter int COL_W      = 12,
    parameter bit NATIVE_565 = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       cfg_depth,
    input  logic             cfg_swap_rb,
    input  logic             cfg_be_byte,
    input  logic             cfg_be_pix,
    input  logic [1:0]       mux_sel,
    input  logic [COL_W-1:0] cfg_cols,
    output logic [COL_W+1:0] bytes_per_line,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [31:0]      in_word,
    output logic             out_valid,
    input  logic             out_ready,
    output logic             out_is_index,
    output logic [7:0]       out_index,
    output logic [7:0]       out_r,
    output logic [7:0]       out_g,
    output logic [7:0]       out_b
);
    cfg_t              cfg_in;
    cfg_t              cfg_q;
    logic [WORD_W-1:0] ordered_word;
    logic [WORD_W-1:0] word_q;
    logic              full_q;
    logic [POS_W-1:0]  pos_q;
    logic              accept;
    logic              last_pix;
    logic [5:0]        ppw;
    logic [WORD_W-1:0] raw;
    pix_t              pix;

    assign cfg_in = '{depth:   depth_e'(cfg_depth),
                      swap_rb: cfg_swap_rb,
                      be_byte: cfg_be_byte,
                      be_pix:  cfg_be_pix,
                      mux:     mux_sel};

    fbu_line_bytes #(.COL_W(COL_W)) u_line (
        .depth (depth_e'(cfg_depth)),
        .cols  (cfg_cols),
        .bytes (bytes_per_line)
    );

    fbu_byte_order u_order (
        .word_in  (in_word),
        .reverse  (cfg_be_byte),
        .word_out (ordered_word)
    );

    assign in_ready = !full_q;
    assign accept   = in_valid && !full_q;
    assign ppw      = pix_per_word(cfg_q.depth);
    assign last_pix = ({1'b0, pos_q} == ppw - 6'd1);

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q <= 1'b0;
            pos_q  <= '0;
            word_q <= '0;
            cfg_q  <= '0;
        end else if (accept) begin
            full_q <= 1'b1;
            pos_q  <= '0;
            word_q <= ordered_word;
            cfg_q  <= cfg_in;
        end else if (full_q && out_ready) begin
            if (last_pix) begin
                full_q <= 1'b0;
                pos_q  <= '0;
            end else begin
                pos_q  <= pos_q + 1'b1;
            end
        end
    end

    fbu_pix_select u_select (
        .word    (word_q),
        .depth   (cfg_q.depth),
        .be_pix  (cfg_q.be_pix),
        .be_byte (cfg_q.be_byte),
        .pos     (pos_q),
        .raw     (raw)
    );

    fbu_color_decode #(.NATIVE_565(NATIVE_565)) u_decode (
        .raw (raw),
        .cfg (cfg_q),
        .pix (pix)
    );

    assign out_valid    = full_q;
    assign out_is_index = pix.is_index;
    assign out_index    = pix.index;
    assign out_r        = pix.r;
    assign out_g        = pix.g;
    assign out_b        = pix.b;
endmodule

// File: rtl/fbu_checker.sv
module fbu_checker #(
    parameter int COL_W = 12
) (
    input logic             clk,
    input logic             rst,
    input logic [2:0]       cfg_depth,
    input logic [COL_W-1:0] cfg_cols,
    input logic [COL_W+1:0] bytes_per_line,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic             out_is_index,
    input logic [7:0]       out_index,
    input logic [7:0]       out_r,
    input logic [7:0]       out_g,
    input logic [7:0]       out_b
);
    AST_BUSY_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready); // R2

    AST_ACCEPT_GIVES_PIXEL: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_valid); // R2

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=>
            (out_valid && $stable({out_is_index, out_index, out_r, out_g, out_b}))); // R2

    AST_INDEX_NO_COLOUR: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_is_index) |-> (out_r == 8'd0 && out_g == 8'd0 && out_b == 8'd0)); // R7

    AST_COLOUR_NO_INDEX: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_is_index) |-> (out_index == 8'd0)); // R7

    AST_LINE_8BPP: assert property (@(posedge clk) disable iff (rst)
        (cfg_depth == 3'd3) |-> (bytes_per_line == (COL_W+2)'(cfg_cols))); // R12

    AST_LINE_32BPP: assert property (@(posedge clk) disable iff (rst)
        (cfg_depth == 3'd5) |-> (bytes_per_line == ((COL_W+2)'(cfg_cols) << 2))); // R12
endmodule

bind fb_unpack fbu_checker #(.COL_W(COL_W)) u_fbu_checker (
    .clk            (clk),
    .rst            (rst),
    .cfg_depth      (cfg_depth),
    .cfg_cols       (cfg_cols),
    .bytes_per_line (bytes_per_line),
    .in_valid       (in_valid),
    .in_ready       (in_ready),
    .out_valid      (out_valid),
    .out_ready      (out_ready),
    .out_is_index   (out_is_index),
    .out_index      (out_index),
    .out_r          (out_r),
    .out_g          (out_g),
    .out_b          (out_b)
);

// File: tb/fb_unpack_tb_top.sv
module fb_unpack_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int COL_W      = 12;
    localparam int WATCHDOG   = 150000;

    logic             clk = 1'b0;
    logic             rst;
    logic [2:0]       cfg_depth;
    logic             cfg_swap_rb;
    logic             cfg_be_byte;
    logic             cfg_be_pix;
    logic [1:0]       mux_sel;
    logic [COL_W-1:0] cfg_cols;
    logic [COL_W+1:0] bytes_per_line;
    logic             in_valid;
    logic             in_ready;
    logic [31:0]      in_word;
    logic             out_valid;
    logic             out_ready;
    logic             out_is_index;
    logic [7:0]       out_index;
    logic [7:0]       out_r;
    logic [7:0]       out_g;
    logic [7:0]       out_b;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fb_unpack #(.COL_W(COL_W), .NATIVE_565(1'b0)) dut_i (
        .clk            (clk),
        .rst            (rst),
        .cfg_depth      (cfg_depth),
        .cfg_swap_rb    (cfg_swap_rb),
        .cfg_be_byte    (cfg_be_byte),
        .cfg_be_pix     (cfg_be_pix),
        .mux_sel        (mux_sel),
        .cfg_cols       (cfg_cols),
        .bytes_per_line (bytes_per_line),
        .in_valid       (in_valid),
        .in_ready       (in_ready),
        .in_word        (in_word),
        .out_valid      (out_valid),
        .out_ready      (out_ready),
        .out_is_index   (out_is_index),
        .out_index      (out_index),
        .out_r          (out_r),
        .out_g          (out_g),
        .out_b          (out_b)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int width_of(input int d);
        case (d)
            0: return 1;
            1: return 2;
            2: return 4;
            3: return 8;
            5: return 32;
            default: return 16;
        endcase
    endfunction

    function automatic logic [COL_W+1:0] exp_bpl(input int d, input int c);
        case (d)
            0: return (COL_W+2)'(c / 8);
            1: return (COL_W+2)'(c / 4);
            2: return (COL_W+2)'(c / 2);
            3: return (COL_W+2)'(c);
            5: return (COL_W+2)'(c * 4);
            default: return (COL_W+2)'(c * 2);
        endcase
    endfunction

    // Returns {is_index, index, r, g, b}
    function automatic logic [32:0] exp_pix(input logic [31:0] w, input int d, input bit swp,
                                            input bit beb, input bit bep, input int mx, input int k);
        logic [31:0] w2;
        logic [31:0] rawv;
        int wd, off;
        logic [7:0] lo, mid, hi, t;
        w2 = beb ? {w[7:0], w[15:8], w[23:16], w[31:24]} : w;
        wd = width_of(d);
        off = k * wd;
        if (wd < 8 && bep && !beb) off = (off / 8) * 8 + (8 - wd - (off % 8));
        rawv = w2 >> off;
        if (wd < 32) rawv = rawv & ((32'd1 << wd) - 1);
        if (d < 4) return {1'b1, rawv[7:0], 24'd0};
        if (d == 5) begin
            lo = rawv[7:0]; mid = rawv[15:8]; hi = rawv[23:16];
        end else if (d == 7) begin
            lo = {rawv[3:0], 4'd0}; mid = {rawv[7:4], 4'd0}; hi = {rawv[11:8], 4'd0};
        end else if (d == 4 && mx == 1) begin
            lo = {rawv[4:0], 3'd0}; mid = {rawv[9:5], 3'd0}; hi = {rawv[14:10], 3'd0};
        end else begin
            lo = {rawv[4:0], 3'd0}; mid = {rawv[10:5], 2'd0}; hi = {rawv[15:11], 3'd0};
            if (d == 4 && mx == 3) swp = 1'b1;
        end
        if (swp) begin t = lo; lo = hi; hi = t; end
        return {1'b0, 8'd0, lo, mid, hi};
    endfunction

    function automatic string tag_of(input int d, input bit swp, input bit beb, input bit bep, input int mx);
        string s;
        s = "R3 R13";
        if (beb) s = {s, " R6"};
        else if (bep) s = {s, " R5"};
        else s = {s, " R4"};
        if (d < 4) s = {s, " R7"};
        else if (d == 4) s = {s, " R9 R10"};
        else if (d == 6) s = {s, " R8 R9"};
        else s = {s, " R8"};
        if (swp) s = {s, " R11"};
        return s;
    endfunction

    task automatic send_word(input logic [31:0] w, input int d, input bit swp, input bit beb,
                             input bit bep, input int mx, input bit stalls);
        int n;
        logic [32:0] e;
        logic [32:0] a;
        string tg;
        tg = tag_of(d, swp, beb, bep, mx);
        @(negedge clk);
        cfg_depth = 3'(d); cfg_swap_rb = swp; cfg_be_byte = beb; cfg_be_pix = bep;
        mux_sel = 2'(mx); in_word = w; in_valid = 1'b1;
        check(in_ready === 1'b1, "R2 ready before word", {63'd0, in_ready}, 64'd1);
        @(posedge clk);
        @(negedge clk);
        // R13: scramble controls and offer junk input while the word drains
        cfg_depth = 3'($urandom); cfg_swap_rb = 1'($urandom); cfg_be_byte = 1'($urandom);
        cfg_be_pix = 1'($urandom); mux_sel = 2'($urandom); in_word = $urandom;
        in_valid = 1'b1;
        n = 32 / width_of(d);
        for (int k = 0; k < n; k++) begin
            int st;
            st = stalls ? int'($urandom % 3) : 0;
            for (int s = 0; s < st; s++) begin
                out_ready = 1'b0;
                check(out_valid === 1'b1 && in_ready === 1'b0, "R2 busy during stall",
                      {62'd0, out_valid, in_ready}, 64'd2);
                @(posedge clk);
                @(negedge clk);
            end
            out_ready = 1'b1;
            e = exp_pix(w, d, swp, beb, bep, mx, k);
            a = {out_is_index, out_index, out_r, out_g, out_b};
            check(out_valid === 1'b1 && a === e, $sformatf("%s pixel %0d depth %0d mux %0d", tg, k, d, mx),
                  {30'd0, out_valid, a}, {30'd0, 1'b1, e});
            @(posedge clk);
            @(negedge clk);
        end
        in_valid = 1'b0;
        out_ready = 1'b0;
        check(out_valid === 1'b0 && in_ready === 1'b1, "R3 word drained after last pixel",
              {62'd0, out_valid, in_ready}, 64'd1);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'h1F2E3D4C));
        rst = 1'b1; cfg_depth = 3'd0; cfg_swap_rb = 1'b0; cfg_be_byte = 1'b0; cfg_be_pix = 1'b0;
        mux_sel = 2'd0; cfg_cols = '0; in_valid = 1'b0; in_word = '0; out_ready = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_valid === 1'b0 && in_ready === 1'b1, "R1 during reset", {62'd0, out_valid, in_ready}, 64'd1);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid === 1'b0 && in_ready === 1'b1, "R1 after reset", {62'd0, out_valid, in_ready}, 64'd1);

        // R12: line size for every depth code
        for (int d = 0; d < 8; d++) begin
            for (int j = 0; j < 3; j++) begin
                int c;
                c = (j == 0) ? 640 : (j == 1) ? 4095 : int'($urandom % 4096);
                cfg_depth = 3'(d); cfg_cols = COL_W'(c);
                #1;
                check(bytes_per_line === exp_bpl(d, c), $sformatf("R12 depth %0d cols %0d", d, c),
                      64'(bytes_per_line), 64'(exp_bpl(d, c)));
            end
        end

        // Directed ordering corners: lone bits and distinct bytes (R4 R5 R6)
        send_word(32'h0000_0001, 0, 0, 0, 0, 0, 0);
        send_word(32'h0000_0001, 0, 0, 0, 1, 0, 0);
        send_word(32'h0000_0001, 0, 0, 1, 0, 0, 0);
        send_word(32'h0000_0001, 0, 0, 1, 1, 0, 0);
        send_word(32'h8000_0040, 1, 0, 0, 1, 0, 0);
        send_word(32'h1234_56C7, 2, 0, 0, 1, 0, 0);
        send_word(32'h1122_3344, 3, 0, 0, 1, 0, 0);
        send_word(32'h1122_3344, 3, 0, 1, 0, 0, 0);
        // Direct-colour corners (R8 R9 R10 R11)
        send_word(32'hFFFF_801F, 4, 0, 0, 0, 1, 0);
        send_word(32'h7C00_F800, 4, 0, 0, 0, 0, 0);
        send_word(32'h7C00_F800, 4, 1, 0, 0, 2, 0);
        send_word(32'h001F_F800, 4, 0, 0, 0, 3, 0);
        send_word(32'h001F_F800, 4, 1, 0, 0, 3, 0);
        send_word(32'hFF12_3456, 5, 1, 0, 0, 0, 0);
        send_word(32'hF123_FABC, 7, 0, 0, 0, 0, 0);
        send_word(32'hF800_07E0, 6, 0, 0, 0, 1, 0);

        // Random mix with output stalls
        for (int i = 0; i < 160; i++) begin
            send_word($urandom, int'($urandom % 8), 1'($urandom), 1'($urandom), 1'($urandom),
                      int'($urandom % 4), 1'b1);
        end

        done = 1;
        finish_run();
    end
endmodule